// File: doc/BRIEF.md
# Error-Correcting Dual-Port Word Memory

This block is a two-port random-access store for 13-bit words. Each word is held with a single-error-correcting, double-error-detecting code. Both ports can write and read, and each has its own path. On the write side, a port's encoder turns the incoming word into a 19-bit codeword before storing it. On the read side, a port's decoder checks the stored codeword, repairs a single flipped bit, and reports what it found through three status flags. A register after each decoder adds one cycle to the read path, so the corrected word and its flags leave the block together.

Each port also has a two-bit fault input that inverts low-order bits of the codeword it is writing. This lets a test deliberately store a single-bit or a double-bit error and observe the decoder's response. The block never writes corrected data back into the array.

Top module: `ecc_dpram`

## Requirements
- R1: A port's address is sampled at a rising clock edge. The word stored there appears on that port's read data after the following rising edge, two edges after the address is presented. Between those two edges the output still shows the previous read.
- R2: The ports are independent. A word written through one port is read back unchanged through either port.
- R3: A word stored with no fault injected reads back with the error, corrected and uncorrectable flags all low. This includes a word overwritten cleanly after it was stored with a fault.
- R4: Fault bit 0 asserted during a write inverts codeword bit 0, the overall parity bit. A read of that word returns the original data with error=1, corrected=1 and uncorrectable=0.
- R5: Fault bit 1 asserted during a write inverts codeword bit 1, the first Hamming check bit. A read returns the original data with error=1, corrected=1 and uncorrectable=0.
- R6: Both fault bits asserted during a write store a double-bit error. A read reports error=1, corrected=0 and uncorrectable=1. The data bits are returned uncorrected, so they equal the original word, because both inverted bits are check bits.
- R7: The error flag equals corrected OR uncorrectable, and corrected and uncorrectable are never high together.
- R8: When both ports write the same address in the same cycle, port A's codeword is the one stored, including its fault bits.
- R9: A read of an address that either port writes in the same cycle returns the content from before that write.
- R10: While rst_n is low, every read data output and every flag is 0.
- R11: The fault inputs have no effect when the port's write enable is low. The stored word keeps reading back clean.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the read pipeline |
| a_we | input | 1 | Port A write enable |
| a_addr | input | AW | Port A address, used for both reading and writing |
| a_wdata | input | 13 | Port A write word |
| a_flip | input | 2 | Port A fault bits: [0] inverts codeword bit 0, [1] inverts codeword bit 1 |
| a_rdata | output | 13 | Port A corrected read word |
| a_err | output | 1 | Port A: any error seen |
| a_corr | output | 1 | Port A: single error corrected |
| a_uncorr | output | 1 | Port A: double error detected |
| b_we | input | 1 | Port B write enable |
| b_addr | input | AW | Port B address |
| b_wdata | input | 13 | Port B write word |
| b_flip | input | 2 | Port B fault bits, same encoding as port A |
| b_rdata | output | 13 | Port B corrected read word |
| b_err | output | 1 | Port B: any error seen |
| b_corr | output | 1 | Port B: single error corrected |
| b_uncorr | output | 1 | Port B: double error detected |

## Verification
The bench writes all-zero, all-one, alternating and sparse words, and reads each one back through both ports. This separates a faulty encoder or data-bit placement from a faulty decoder. Words stored with fault pattern 01, 10 and 11 show whether parity-bit repair, check-bit repair and double-error detection each set the right flag while leaving the data intact. Writes from both ports to the same address in the same cycle, with only port B's fault bits set, show which port wins and whether B's fault bits leak into the stored word. Reads aimed at the address being written, and back-to-back reads of two different words, pin down the old-data rule and the exact two-edge latency.

// File: rtl/ecc_dpram_pkg.sv
package ecc_dpram_pkg;
  localparam int DW     = 13;            // data bits per word
  localparam int PW     = 5;             // Hamming check bits
  localparam int CW     = DW + PW + 1;   // plus overall parity at bit 0
  localparam int FLIP_W = 2;             // fault-injection bits per port

  typedef logic [DW-1:0] data_t;
  typedef logic [CW-1:0] cw_t;

  typedef struct packed {
    data_t data;
    logic  err;
    logic  corr;
    logic  uncorr;
  } dec_t;

  // positions 1..CW-1 follow Hamming numbering; powers of two hold checks
  function automatic bit is_check_pos(int pos);
    return (pos & (pos - 1)) == 0;
  endfunction

  function automatic cw_t ecc_encode(data_t d);
    cw_t c;
    int  k;
    c = '0;
    k = 0;
    for (int pos = 1; pos < CW; pos++) begin
      if (!is_check_pos(pos)) begin
        c[pos] = d[k];
        k++;
      end
    end
    for (int j = 0; j < PW; j++) begin
      logic p;
      p = 1'b0;
      for (int pos = 1; pos < CW; pos++) begin
        if (((pos >> j) & 1) != 0) p = p ^ c[pos];
      end
      c[1 << j] = p;
    end
    c[0] = ^c[CW-1:1];
    return c;
  endfunction

  function automatic logic [PW-1:0] ecc_syndrome(cw_t c);
    logic [PW-1:0] s;
    s = '0;
    for (int pos = 1; pos < CW; pos++) begin
      if (c[pos]) s = s ^ PW'(pos);
    end
    return s;
  endfunction

  function automatic data_t ecc_extract(cw_t c);
    data_t d;
    int    k;
    d = '0;
    k = 0;
    for (int pos = 1; pos < CW; pos++) begin
      if (!is_check_pos(pos)) begin
        d[k] = c[pos];
        k++;
      end
    end
    return d;
  endfunction

  function automatic dec_t ecc_decode(cw_t c);
    dec_t          r;
    logic [PW-1:0] s;
    logic          odd;
    cw_t           fixed;
    s      = ecc_syndrome(c);
    odd    = ^c;
    fixed  = c;
    r.corr   = 1'b0;
    r.uncorr = 1'b0;
    if (odd) begin
      if (s == '0) begin
        fixed[0] = ~fixed[0];
        r.corr   = 1'b1;
      end else if (int'(s) < CW) begin
        fixed[s] = ~fixed[s];
        r.corr   = 1'b1;
      end else begin
        r.uncorr = 1'b1;
      end
    end else if (s != '0) begin
      r.uncorr = 1'b1;
    end
    r.err  = r.corr | r.uncorr;
    r.data = ecc_extract(fixed);
    return r;
  endfunction
endpackage

// File: rtl/ecc_enc.sv
module ecc_enc
  import ecc_dpram_pkg::*;
(
  input  data_t             din,
  input  logic [FLIP_W-1:0] flip,
  output cw_t               cw
);
  cw_t clean_cw;

  assign clean_cw = ecc_encode(din);
  assign cw       = clean_cw ^ CW'(flip);
endmodule

// File: rtl/ecc_dec.sv
module ecc_dec
  import ecc_dpram_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cw_t  cw,
  output dec_t pre,
  output dec_t q
);
  assign pre = ecc_decode(cw);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= pre;
  end
endmodule

// File: rtl/ecc_mem.sv
module ecc_mem
  import ecc_dpram_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  cw_t           a_cw,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  cw_t           b_cw,
  output cw_t           a_rcw,
  output cw_t           b_rcw
);
  localparam int DEPTH = 1 << AW;

  cw_t store [DEPTH];

  // later assignment wins: port A has priority on a shared address
  always_ff @(posedge clk) begin
    if (b_we) store[b_addr] <= b_cw;
    if (a_we) store[a_addr] <= a_cw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_rcw <= '0;
      b_rcw <= '0;
    end else begin
      a_rcw <= store[a_addr];
      b_rcw <= store[b_addr];
    end
  end
endmodule

// File: rtl/ecc_dpram.sv
module ecc_dpram
  import ecc_dpram_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_we,
  input  logic [AW-1:0]     a_addr,
  input  logic [DW-1:0]     a_wdata,
  input  logic [FLIP_W-1:0] a_flip,
  output logic [DW-1:0]     a_rdata,
  output logic              a_err,
  output logic              a_corr,
  output logic              a_uncorr,
  input  logic              b_we,
  input  logic [AW-1:0]     b_addr,
  input  logic [DW-1:0]     b_wdata,
  input  logic [FLIP_W-1:0] b_flip,
  output logic [DW-1:0]     b_rdata,
  output logic              b_err,
  output logic              b_corr,
  output logic              b_uncorr
);
  cw_t  a_enc_cw, b_enc_cw;
  cw_t  a_raw_cw, b_raw_cw;
  dec_t a_pre, b_pre;
  dec_t a_q, b_q;

  ecc_enc u_enc_a (.din(a_wdata), .flip(a_flip), .cw(a_enc_cw));
  ecc_enc u_enc_b (.din(b_wdata), .flip(b_flip), .cw(b_enc_cw));

  ecc_mem #(.AW(AW)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .a_we(a_we), .a_addr(a_addr), .a_cw(a_enc_cw),
    .b_we(b_we), .b_addr(b_addr), .b_cw(b_enc_cw),
    .a_rcw(a_raw_cw), .b_rcw(b_raw_cw)
  );

  ecc_dec u_dec_a (.clk(clk), .rst_n(rst_n), .cw(a_raw_cw), .pre(a_pre), .q(a_q));
  ecc_dec u_dec_b (.clk(clk), .rst_n(rst_n), .cw(b_raw_cw), .pre(b_pre), .q(b_q));

  assign a_rdata  = a_q.data;
  assign a_err    = a_q.err;
  assign a_corr   = a_q.corr;
  assign a_uncorr = a_q.uncorr;
  assign b_rdata  = b_q.data;
  assign b_err    = b_q.err;
  assign b_corr   = b_q.corr;
  assign b_uncorr = b_q.uncorr;
endmodule

// File: rtl/ecc_dpram_chk.sv
module ecc_dpram_chk
  import ecc_dpram_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              a_we,
  input logic              b_we,
  input logic [FLIP_W-1:0] a_flip,
  input logic [FLIP_W-1:0] b_flip,
  input cw_t               a_enc_cw,
  input cw_t               b_enc_cw,
  input dec_t              a_pre,
  input dec_t              b_pre,
  input logic [DW-1:0]     a_rdata,
  input logic [DW-1:0]     b_rdata,
  input logic              a_err,
  input logic              a_corr,
  input logic              a_uncorr,
  input logic              b_err,
  input logic              b_corr,
  input logic              b_uncorr
);
  // R7: flags are consistent at the ports
  assert_flag_excl_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_corr && a_uncorr));
  assert_flag_excl_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(b_corr && b_uncorr));
  assert_err_union_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
    a_err == (a_corr || a_uncorr));
  assert_err_union_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
    b_err == (b_corr || b_uncorr));

  // R1: outputs carry the decoder result exactly one edge later
  assert_latency_a_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (a_rdata == $past(a_pre.data)) && (a_corr == $past(a_pre.corr)) && (a_uncorr == $past(a_pre.uncorr)));
  assert_latency_b_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (b_rdata == $past(b_pre.data)) && (b_corr == $past(b_pre.corr)) && (b_uncorr == $past(b_pre.uncorr)));

  // R4 R5 R6: stored parity is odd exactly when an odd number of bits is flipped
  assert_enc_parity_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
    a_we |-> ((^a_enc_cw) == (^a_flip)));
  assert_enc_parity_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
    b_we |-> ((^b_enc_cw) == (^b_flip)));
endmodule

bind ecc_dpram ecc_dpram_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .a_we(a_we), .b_we(b_we),
  .a_flip(a_flip), .b_flip(b_flip),
  .a_enc_cw(a_enc_cw), .b_enc_cw(b_enc_cw),
  .a_pre(a_pre), .b_pre(b_pre),
  .a_rdata(a_rdata), .b_rdata(b_rdata),
  .a_err(a_err), .a_corr(a_corr), .a_uncorr(a_uncorr),
  .b_err(b_err), .b_corr(b_corr), .b_uncorr(b_uncorr)
);

// File: tb/sim_ecc_dpram.sv
module sim_ecc_dpram;
  import ecc_dpram_pkg::*;

  localparam int AW    = 5;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          a_we = 1'b0, b_we = 1'b0;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  data_t         a_wdata = '0, b_wdata = '0;
  logic [1:0]    a_flip = '0, b_flip = '0;
  data_t         a_rdata, b_rdata;
  logic          a_err, a_corr, a_uncorr, b_err, b_corr, b_uncorr;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  // reference: word and error kind (0 clean, 1 single, 2 double)
  data_t mdl_d [DEPTH];
  int    mdl_k [DEPTH];

  always #4 clk = ~clk;

  ecc_dpram #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_flip(a_flip),
    .a_rdata(a_rdata), .a_err(a_err), .a_corr(a_corr), .a_uncorr(a_uncorr),
    .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_flip(b_flip),
    .b_rdata(b_rdata), .b_err(b_err), .b_corr(b_corr), .b_uncorr(b_uncorr)
  );

  task automatic chk(string req, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  task automatic chk_port(bit port, string req, data_t ed, int kind);
    if (port == 1'b0) begin
      chk(req, "A data", int'(a_rdata), int'(ed));
      chk(req, "A err", int'(a_err), int'(kind != 0));
      chk(req, "A corr", int'(a_corr), int'(kind == 1));
      chk(req, "A uncorr", int'(a_uncorr), int'(kind == 2));
    end else begin
      chk(req, "B data", int'(b_rdata), int'(ed));
      chk(req, "B err", int'(b_err), int'(kind != 0));
      chk(req, "B corr", int'(b_corr), int'(kind == 1));
      chk(req, "B uncorr", int'(b_uncorr), int'(kind == 2));
    end
  endtask

  function automatic int flip_kind(logic [1:0] f);
    return (f == 2'b00) ? 0 : ((f == 2'b11) ? 2 : 1);
  endfunction

  task automatic wr(bit port, int addr, data_t d, logic [1:0] f);
    @(negedge clk);
    if (port == 1'b0) begin
      a_we = 1'b1; a_addr = AW'(addr); a_wdata = d; a_flip = f;
    end else begin
      b_we = 1'b1; b_addr = AW'(addr); b_wdata = d; b_flip = f;
    end
    @(negedge clk);
    a_we = 1'b0; b_we = 1'b0; a_flip = '0; b_flip = '0;
    mdl_d[addr] = d;
    mdl_k[addr] = flip_kind(f);
  endtask

  task automatic rd(bit port, int addr, string req);
    @(negedge clk);
    if (port == 1'b0) a_addr = AW'(addr);
    else              b_addr = AW'(addr);
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    chk_port(port, req, mdl_d[addr], mdl_k[addr]);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk_port(1'b0, "R10", '0, 0);
    chk_port(1'b1, "R10", '0, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_clean_patterns;
    data_t pats [6] = '{13'h0000, 13'h1FFF, 13'h1555, 13'h0AAA, 13'h0001, 13'h1000};
    for (int i = 0; i < 6; i++) wr(1'b0, i, pats[i], 2'b00);
    for (int i = 0; i < 6; i++) rd(1'b0, i, "R3");
  endtask

  task automatic t_latency;
    wr(1'b0, 10, 13'h0123, 2'b00);
    wr(1'b0, 11, 13'h1ABC, 2'b00);
    @(negedge clk); a_addr = 5'd10;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R1", "first word", int'(a_rdata), 32'h0123);
    a_addr = 5'd11;
    @(posedge clk); @(negedge clk);
    chk("R1", "one edge later still old", int'(a_rdata), 32'h0123);
    @(posedge clk); @(negedge clk);
    chk("R1", "two edges later new", int'(a_rdata), 32'h1ABC);
  endtask

  task automatic t_cross;
    wr(1'b0, 12, 13'h0F3C, 2'b00);
    rd(1'b1, 12, "R2");
    wr(1'b1, 13, 13'h10C7, 2'b00);
    rd(1'b0, 13, "R2");
  endtask

  task automatic t_single_bit0;
    wr(1'b0, 14, 13'h1234, 2'b01);
    rd(1'b0, 14, "R4");
    rd(1'b1, 14, "R4");
  endtask

  task automatic t_single_bit1;
    wr(1'b1, 15, 13'h0765, 2'b10);
    rd(1'b1, 15, "R5");
    rd(1'b0, 15, "R5");
  endtask

  task automatic t_double;
    wr(1'b0, 16, 13'h1E0F, 2'b11);
    rd(1'b0, 16, "R6");
    wr(1'b1, 17, 13'h0000, 2'b11);
    rd(1'b1, 17, "R6");
    // clean overwrite removes the stored fault
    wr(1'b1, 16, 13'h02D2, 2'b00);
    rd(1'b0, 16, "R3");
  endtask

  task automatic t_collide;
    @(negedge clk);
    a_we = 1'b1; a_addr = 5'd9; a_wdata = 13'h0ACE; a_flip = 2'b00;
    b_we = 1'b1; b_addr = 5'd9; b_wdata = 13'h1531; b_flip = 2'b11;
    @(negedge clk);
    a_we = 1'b0; b_we = 1'b0; a_flip = '0; b_flip = '0;
    mdl_d[9] = 13'h0ACE;
    mdl_k[9] = 0;
    rd(1'b0, 9, "R8");
    rd(1'b1, 9, "R8");
  endtask

  task automatic t_read_during_write;
    data_t old_d;
    wr(1'b0, 20, 13'h0333, 2'b00);
    old_d = mdl_d[20];
    @(negedge clk);
    a_we = 1'b1; a_addr = 5'd20; a_wdata = 13'h1CCC; a_flip = 2'b00;
    b_addr = 5'd20;
    @(negedge clk);
    a_we = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R9", "B sees old", int'(b_rdata), int'(old_d));
    chk("R9", "A sees old", int'(a_rdata), int'(old_d));
    mdl_d[20] = 13'h1CCC;
    mdl_k[20] = 0;
    rd(1'b1, 20, "R9");
  endtask

  task automatic t_flip_ignored;
    wr(1'b0, 21, 13'h0F0F, 2'b00);
    @(negedge clk);
    a_we = 1'b0; a_addr = 5'd21; a_flip = 2'b11; a_wdata = 13'h1111;
    b_we = 1'b0; b_addr = 5'd21; b_flip = 2'b01; b_wdata = 13'h0222;
    @(negedge clk);
    a_flip = '0; b_flip = '0;
    rd(1'b0, 21, "R11");
    rd(1'b1, 21, "R11");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_clean_patterns();
    t_latency();
    t_cross();
    t_single_bit0();
    t_single_bit1();
    t_double();
    t_collide();
    t_read_during_write();
    t_flip_ignored();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule